// File: doc/BRIEF.md
# Nibble Command Sequencer with Start-up Gate

This block sits behind a host port that delivers one transfer at a time. Each transfer carries a flag telling whether it is a command nibble or a data nibble. The block groups command nibbles into whole commands. A command is a header nibble, one or two first-level nibbles, and, for some headers, four second-level nibbles. The header value fixes how long the command is. The block checks each field and pulses an action strobe carrying the header, the collected selector and the collected word. When a command asks for a status value, or when a field is bad, the block queues a 16-bit reply word for the host.

After reset the block serves only one command: the clock-source selection (header 0xB, argument 0x1 or 0x2). Any other transfer during that phase sends the block back to waiting for 0xB. Once it is initialised, a play command can switch the block into one of two playback modes. In nibble playback, data nibbles are forwarded and commands still parse. In byte playback, every transfer is forwarded as an 8-bit data byte and nothing is parsed. A play-end pulse returns the block to plain command reception. The request output is active high; the host-side ready line is its inverse.

Top module: `nib_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `accept_req` is 1, `init_done` is 0, `rep_vld` is 0 and `act_vld` is 0.
- R2: Before `init_done`, only a command 0xB followed by a command 0x1 or 0x2 completes start-up. That sequence raises `init_done`, sets `osc_mode` to the argument, and pulses `act_vld` with `act_hdr`=0xB. Any other transfer, data-flagged ones included, restarts the wait for 0xB. During start-up no reply is queued and no data is forwarded.
- R3: A transfer is taken when `xfer_vld` and `accept_req` are both 1. In the cycle after a take, `accept_req` is 0. In the cycle after that it returns to 1, unless the reply queue is full.
- R4: Header 0x1 takes two nibbles forming an 8-bit address, first nibble in bits 7:4. It then takes four nibbles forming a 16-bit word, first nibble in bits 15:12. One cycle after the last nibble, `act_vld` pulses with `act_hdr`=1, `act_sel`=address and `act_word`=word.
- R5: Headers 0x2, 0x4, 0x5, 0x6, 0x7, 0x8, 0x9 and 0xB take one selector nibble v and pulse `act_vld` with `act_sel`={0,v} and `act_word`=0. The valid ranges are: 0x4: 1–7; 0x5: 1–3; 0x6: 1–6; 0x7: 2 only; 0x8: 1–3; 0xB: 1–2; 0x2 and 0x9: any value.
- R6: Header 0xA takes a selector of 0–2 and then four nibbles that form `act_word`, first nibble in bits 15:12.
- R7: Headers 0x0, 0x3, 0xC, 0xD, 0xE and 0xF, and any selector outside its range, queue the reply 0x9999 and produce no action pulse. The nibble that follows is parsed as a new header.
- R8: A data-flagged transfer (`xfer_is_data`=1) that arrives part-way through a command drops the partial command and queues 0x9999. That transfer is not forwarded.
- R9: Header 0x7 with selector 0x2 queues the value of `buf_need` as it stands in the cycle of the selector's take.
- R10: Outside a command and outside byte playback, a data-flagged transfer pulses `data_vld` one cycle later with `data_val`={4'h0, `xfer_bus`[3:0]}.
- R11: Header 0x4 with selector 1, 4, 5 or 6 sets `playing`. Selector 2 sets both `playing` and `wide_mode`. In `wide_mode`, every taken transfer pulses `data_vld` with the full `xfer_bus`, whatever its flag, and no action pulses. Header 0x5 with selector 1, or a `play_end` pulse, clears `playing` and `wide_mode`.
- R12: Replies leave in the order they were queued. `rep_vld` is 1 while the queue holds an entry, `rep_word` shows the oldest entry, and `rep_pop` removes it. While two replies are held, `accept_req` stays 0.
- R13: After start-up, header 0xB with selector 1 or 2 changes `osc_mode` to that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_vld | input | 1 | Host offers a transfer |
| xfer_bus | input | 8 | Transfer value; commands use bits 3:0 |
| xfer_is_data | input | 1 | 1 = data transfer, 0 = command nibble |
| accept_req | output | 1 | Block ready to take a transfer |
| play_end | input | 1 | Playback has finished |
| buf_need | input | 16 | Buffer fill count returned by header 0x7 |
| act_vld | output | 1 | One-cycle action strobe |
| act_hdr | output | 4 | Header of the completed command |
| act_sel | output | 8 | Collected selector or address |
| act_word | output | 16 | Collected second-level word |
| data_vld | output | 1 | One-cycle forwarded-data strobe |
| data_val | output | 8 | Forwarded data |
| playing | output | 1 | A playback mode is active |
| wide_mode | output | 1 | Byte playback is active |
| osc_mode | output | 2 | Selected clock source |
| init_done | output | 1 | Start-up sequence finished |
| rep_vld | output | 1 | Reply queue not empty |
| rep_word | output | 16 | Oldest reply |
| rep_pop | input | 1 | Host removes the oldest reply |

## Verification
Some rules are checked on every cycle. These are:
- the drop of the request after each take;
- the absence of replies, forwarded data and playback before start-up ends;
- that start-up, once done, stays done;
- that the reply queue is never written while full;
- that action and data strobes never coincide;
- that no action appears once byte playback is under way;
- that a waiting reply stays unchanged until it is popped.

Other behaviour depends on a sequence of nibbles, so only the bench scenarios can show it. This covers the length of each command, the nibble order inside addresses and words, the value ranges, the restart during start-up, the abort on a data nibble mid-command, the mode changes and the reply order.

// File: rtl/nib_cmd_pkg.sv
package nib_cmd_pkg;

    localparam int NIB_W = 4;
    localparam int BUS_W = 8;
    localparam int SEL_W = 2 * NIB_W;
    localparam int REP_W = 4 * NIB_W;
    localparam int CNT_W = 3;

    localparam logic [REP_W-1:0] ERR_REPLY = 16'h9999;

    // Header values (decoded by the host, so their encoding is fixed)
    localparam logic [NIB_W-1:0] H_REGWR = 4'h1;
    localparam logic [NIB_W-1:0] H_PORT  = 4'h2;
    localparam logic [NIB_W-1:0] H_PLAY  = 4'h4;
    localparam logic [NIB_W-1:0] H_STOP  = 4'h5;
    localparam logic [NIB_W-1:0] H_VOL   = 4'h6;
    localparam logic [NIB_W-1:0] H_STAT  = 4'h7;
    localparam logic [NIB_W-1:0] H_SLEEP = 4'h8;
    localparam logic [NIB_W-1:0] H_MDATA = 4'h9;
    localparam logic [NIB_W-1:0] H_SHIFT = 4'hA;
    localparam logic [NIB_W-1:0] H_OSC   = 4'hB;

    typedef enum logic [2:0] {
        ST_BOOT_HDR,
        ST_BOOT_ARG,
        ST_HDR,
        ST_LVL1,
        ST_LVL2
    } seq_st_t;

    typedef enum logic [1:0] {
        PM_OFF,
        PM_NIB,
        PM_WIDE
    } play_t;

    typedef struct packed {
        seq_st_t          st;
        play_t            play;
        logic [NIB_W-1:0] hdr;
        logic [SEL_W-1:0] sel;
        logic [REP_W-1:0] word;
        logic [CNT_W-1:0] left;
        logic             busy;
        logic [1:0]       osc;
        logic             init_done;
        logic             act_vld;
        logic [NIB_W-1:0] act_hdr;
        logic [SEL_W-1:0] act_sel;
        logic [REP_W-1:0] act_word;
        logic             data_vld;
        logic [BUS_W-1:0] data_val;
    } seq_regs_t;

endpackage

// File: rtl/cmd_field_rules.sv
module cmd_field_rules
    import nib_cmd_pkg::*;
(
    input  logic [NIB_W-1:0] hdr,
    input  logic [NIB_W-1:0] nib,
    output logic             known,
    output logic [1:0]       lvl1_len,
    output logic [CNT_W-1:0] lvl2_len,
    output logic             lvl1_ok
);

    always_comb begin
        known    = 1'b1;
        lvl1_len = 2'd1;
        lvl2_len = '0;
        lvl1_ok  = 1'b0;
        unique case (hdr)
            H_REGWR: begin
                lvl1_len = 2'd2;
                lvl2_len = CNT_W'(4);
                lvl1_ok  = 1'b1;
            end
            H_PORT:  lvl1_ok = 1'b1;
            H_MDATA: lvl1_ok = 1'b1;
            H_PLAY:  lvl1_ok = (nib >= 4'h1) && (nib <= 4'h7);
            H_STOP:  lvl1_ok = (nib >= 4'h1) && (nib <= 4'h3);
            H_SLEEP: lvl1_ok = (nib >= 4'h1) && (nib <= 4'h3);
            H_VOL:   lvl1_ok = (nib >= 4'h1) && (nib <= 4'h6);
            H_STAT:  lvl1_ok = (nib == 4'h2);
            H_OSC:   lvl1_ok = (nib == 4'h1) || (nib == 4'h2);
            H_SHIFT: begin
                lvl2_len = CNT_W'(4);
                lvl1_ok  = (nib <= 4'h2);
            end
            default: known = 1'b0;
        endcase
    end

endmodule

// File: rtl/reply_fifo.sv
module reply_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic             full,
    output logic             empty,
    output logic [WIDTH-1:0] head
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_d, wr_q, rd_d, rd_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             do_push, do_pop;
    logic [DEPTH-1:0][WIDTH-1:0] slots;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_q];

    always_comb begin
        wr_d  = wr_q;
        rd_d  = rd_q;
        cnt_d = cnt_q;
        if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
        if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
        if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
        if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (do_push && (wr_q == PTR_W'(i)))
                slot_q <= din;
        end
        assign slots[i] = slot_q;
    end

endmodule

// File: rtl/seq_parser.sv
module seq_parser
    import nib_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_vld,
    input  logic [BUS_W-1:0] xfer_bus,
    input  logic             xfer_is_data,
    input  logic             play_end,
    input  logic [REP_W-1:0] buf_need,
    input  logic             fifo_full,
    output logic             accept_req,
    output logic             push,
    output logic [REP_W-1:0] push_word,
    output logic             act_vld,
    output logic [NIB_W-1:0] act_hdr,
    output logic [SEL_W-1:0] act_sel,
    output logic [REP_W-1:0] act_word,
    output logic             data_vld,
    output logic [BUS_W-1:0] data_val,
    output logic             playing,
    output logic             wide_mode,
    output logic [1:0]       osc_mode,
    output logic             init_done
);

    seq_regs_t q, d;

    logic             take;
    logic [NIB_W-1:0] nib;
    logic [NIB_W-1:0] rule_hdr;
    logic             rule_known;
    logic [1:0]       rule_l1_len;
    logic [CNT_W-1:0] rule_l2_len;
    logic             rule_l1_ok;
    logic             finish;
    logic             abort;

    assign nib        = xfer_bus[NIB_W-1:0];
    assign accept_req = !q.busy && !fifo_full;
    assign take       = xfer_vld && accept_req;
    assign rule_hdr   = (q.st == ST_HDR) ? nib : q.hdr;

    cmd_field_rules u_rules (
        .hdr      (rule_hdr),
        .nib      (nib),
        .known    (rule_known),
        .lvl1_len (rule_l1_len),
        .lvl2_len (rule_l2_len),
        .lvl1_ok  (rule_l1_ok)
    );

    always_comb begin
        d          = q;
        d.busy     = take;
        d.act_vld  = 1'b0;
        d.data_vld = 1'b0;
        push       = 1'b0;
        push_word  = ERR_REPLY;
        finish     = 1'b0;
        abort      = 1'b0;

        if (play_end) d.play = PM_OFF;

        if (take) begin
            unique case (q.st)
                ST_BOOT_HDR: begin
                    d.st = (!xfer_is_data && nib == H_OSC) ? ST_BOOT_ARG : ST_BOOT_HDR;
                end
                ST_BOOT_ARG: begin
                    if (!xfer_is_data && (nib == 4'h1 || nib == 4'h2)) begin
                        d.st        = ST_HDR;
                        d.init_done = 1'b1;
                        d.osc       = nib[1:0];
                        d.act_vld   = 1'b1;
                        d.act_hdr   = H_OSC;
                        d.act_sel   = {{(SEL_W-NIB_W){1'b0}}, nib};
                        d.act_word  = '0;
                    end else begin
                        d.st = ST_BOOT_HDR;
                    end
                end
                ST_HDR: begin
                    if (q.play == PM_WIDE) begin
                        d.data_vld = 1'b1;
                        d.data_val = xfer_bus;
                    end else if (xfer_is_data) begin
                        d.data_vld = 1'b1;
                        d.data_val = {{(BUS_W-NIB_W){1'b0}}, nib};
                    end else if (!rule_known) begin
                        push = 1'b1;
                    end else begin
                        d.hdr  = nib;
                        d.sel  = '0;
                        d.word = '0;
                        d.left = {1'b0, rule_l1_len};
                        d.st   = ST_LVL1;
                    end
                end
                ST_LVL1: begin
                    if (xfer_is_data) begin
                        abort = 1'b1;
                    end else begin
                        d.sel = {q.sel[SEL_W-NIB_W-1:0], nib};
                        if (q.left == CNT_W'(1)) begin
                            if (!rule_l1_ok) begin
                                abort = 1'b1;
                            end else if (rule_l2_len != '0) begin
                                d.st   = ST_LVL2;
                                d.left = rule_l2_len;
                            end else begin
                                finish = 1'b1;
                            end
                        end else begin
                            d.left = q.left - 1'b1;
                        end
                    end
                end
                ST_LVL2: begin
                    if (xfer_is_data) begin
                        abort = 1'b1;
                    end else begin
                        d.word = {q.word[REP_W-NIB_W-1:0], nib};
                        if (q.left == CNT_W'(1)) finish = 1'b1;
                        else d.left = q.left - 1'b1;
                    end
                end
                default: d.st = ST_BOOT_HDR;
            endcase
        end

        if (abort) begin
            push = 1'b1;
            d.st = ST_HDR;
        end

        if (finish) begin
            d.st       = ST_HDR;
            d.act_vld  = 1'b1;
            d.act_hdr  = q.hdr;
            d.act_sel  = d.sel;
            d.act_word = d.word;
            unique case (q.hdr)
                H_PLAY: begin
                    if (d.sel[NIB_W-1:0] == 4'h2)
                        d.play = PM_WIDE;
                    else if (d.sel[NIB_W-1:0] == 4'h1 || d.sel[NIB_W-1:0] == 4'h4 ||
                             d.sel[NIB_W-1:0] == 4'h5 || d.sel[NIB_W-1:0] == 4'h6)
                        d.play = PM_NIB;
                end
                H_STOP: if (d.sel[NIB_W-1:0] == 4'h1) d.play = PM_OFF;
                H_STAT: begin
                    push      = 1'b1;
                    push_word = buf_need;
                end
                H_OSC:  d.osc = d.sel[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_BOOT_HDR;
            q.play      <= PM_OFF;
        end else begin
            q <= d;
        end
    end

    assign act_vld   = q.act_vld;
    assign act_hdr   = q.act_hdr;
    assign act_sel   = q.act_sel;
    assign act_word  = q.act_word;
    assign data_vld  = q.data_vld;
    assign data_val  = q.data_val;
    assign playing   = (q.play != PM_OFF);
    assign wide_mode = (q.play == PM_WIDE);
    assign osc_mode  = q.osc;
    assign init_done = q.init_done;

endmodule

// File: rtl/nib_cmd_seq.sv
module nib_cmd_seq
    import nib_cmd_pkg::*;
#(
    parameter int REP_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_vld,
    input  logic [BUS_W-1:0] xfer_bus,
    input  logic             xfer_is_data,
    output logic             accept_req,
    input  logic             play_end,
    input  logic [REP_W-1:0] buf_need,
    output logic             act_vld,
    output logic [NIB_W-1:0] act_hdr,
    output logic [SEL_W-1:0] act_sel,
    output logic [REP_W-1:0] act_word,
    output logic             data_vld,
    output logic [BUS_W-1:0] data_val,
    output logic             playing,
    output logic             wide_mode,
    output logic [1:0]       osc_mode,
    output logic             init_done,
    output logic             rep_vld,
    output logic [REP_W-1:0] rep_word,
    input  logic             rep_pop
);

    logic             rep_push;
    logic [REP_W-1:0] rep_din;
    logic             rep_full;
    logic             rep_empty;

    seq_parser u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_vld     (xfer_vld),
        .xfer_bus     (xfer_bus),
        .xfer_is_data (xfer_is_data),
        .play_end     (play_end),
        .buf_need     (buf_need),
        .fifo_full    (rep_full),
        .accept_req   (accept_req),
        .push         (rep_push),
        .push_word    (rep_din),
        .act_vld      (act_vld),
        .act_hdr      (act_hdr),
        .act_sel      (act_sel),
        .act_word     (act_word),
        .data_vld     (data_vld),
        .data_val     (data_val),
        .playing      (playing),
        .wide_mode    (wide_mode),
        .osc_mode     (osc_mode),
        .init_done    (init_done)
    );

    reply_fifo #(
        .WIDTH (REP_W),
        .DEPTH (REP_DEPTH)
    ) u_reply (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rep_push),
        .din   (rep_din),
        .pop   (rep_pop),
        .full  (rep_full),
        .empty (rep_empty),
        .head  (rep_word)
    );

    assign rep_vld = !rep_empty;

endmodule

// File: rtl/nib_cmd_seq_chk.sv
module nib_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_vld,
    input logic        accept_req,
    input logic        act_vld,
    input logic        data_vld,
    input logic        playing,
    input logic        wide_mode,
    input logic        init_done,
    input logic        rep_vld,
    input logic [15:0] rep_word,
    input logic        rep_pop,
    input logic        rep_push,
    input logic        rep_full
);

    assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_vld && accept_req) |=> !accept_req);

    assert_boot_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (!rep_vld && !data_vld && !playing));

    assert_boot_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_act_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_vld |=> !act_vld);

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_vld && data_vld));

    assert_wide_no_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && $past(wide_mode)) |-> !act_vld);

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rep_full |-> !rep_push);

    assert_reply_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_vld && !rep_pop) |=> (rep_vld && $stable(rep_word)));

endmodule

bind nib_cmd_seq nib_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_vld   (xfer_vld),
    .accept_req (accept_req),
    .act_vld    (act_vld),
    .data_vld   (data_vld),
    .playing    (playing),
    .wide_mode  (wide_mode),
    .init_done  (init_done),
    .rep_vld    (rep_vld),
    .rep_word   (rep_word),
    .rep_pop    (rep_pop),
    .rep_push   (rep_push),
    .rep_full   (rep_full)
);

// File: tb/sim_nib_cmd_seq.sv
`timescale 1ns/1ps
module sim_nib_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_vld = 1'b0;
    logic [7:0]  xfer_bus = '0;
    logic        xfer_is_data = 1'b0;
    logic        accept_req;
    logic        play_end = 1'b0;
    logic [15:0] buf_need = '0;
    logic        act_vld;
    logic [3:0]  act_hdr;
    logic [7:0]  act_sel;
    logic [15:0] act_word;
    logic        data_vld;
    logic [7:0]  data_val;
    logic        playing, wide_mode, init_done, rep_vld;
    logic [1:0]  osc_mode;
    logic [15:0] rep_word;
    logic        rep_pop = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        s_act, s_data, s_acc;
    logic [3:0]  s_hdr;
    logic [7:0]  s_sel, s_dval;
    logic [15:0] s_word;
    logic [1:0]  osc_exp;

    always #2.5 clk = ~clk;

    nib_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .xfer_vld(xfer_vld), .xfer_bus(xfer_bus),
        .xfer_is_data(xfer_is_data), .accept_req(accept_req), .play_end(play_end),
        .buf_need(buf_need), .act_vld(act_vld), .act_hdr(act_hdr), .act_sel(act_sel),
        .act_word(act_word), .data_vld(data_vld), .data_val(data_val),
        .playing(playing), .wide_mode(wide_mode), .osc_mode(osc_mode),
        .init_done(init_done), .rep_vld(rep_vld), .rep_word(rep_word), .rep_pop(rep_pop)
    );

    function automatic bit m_known(input logic [3:0] h);
        return !(h == 4'h0 || h == 4'h3 || h >= 4'hC);
    endfunction

    function automatic bit m_sel_ok(input logic [3:0] h, input logic [3:0] v);
        case (h)
            4'h4: return v >= 1 && v <= 7;
            4'h5, 4'h8: return v >= 1 && v <= 3;
            4'h6: return v >= 1 && v <= 6;
            4'h7: return v == 2;
            4'hA: return v <= 2;
            4'hB: return v == 1 || v == 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input bit is_data, input logic [7:0] bus);
        while (!accept_req) @(negedge clk);
        xfer_vld = 1'b1; xfer_bus = bus; xfer_is_data = is_data;
        @(posedge clk);
        @(negedge clk);
        xfer_vld = 1'b0;
        s_act = act_vld; s_hdr = act_hdr; s_sel = act_sel; s_word = act_word;
        s_data = data_vld; s_dval = data_val; s_acc = accept_req;
    endtask

    task automatic cmd(input logic [3:0] n);
        send(1'b0, {4'h0, n});
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 3; i >= 0; i--) cmd(w[i*4 +: 4]);
    endtask

    task automatic expect_act(input logic [3:0] h, input logic [7:0] sel, input logic [15:0] w, input string tag);
        check(s_act === 1'b1, {tag, " act_vld"}, 32'(s_act), 1);
        check(s_hdr === h, {tag, " act_hdr"}, 32'(s_hdr), 32'(h));
        check(s_sel === sel, {tag, " act_sel"}, 32'(s_sel), 32'(sel));
        check(s_word === w, {tag, " act_word"}, 32'(s_word), 32'(w));
    endtask

    task automatic pop_expect(input logic [15:0] w, input string tag);
        check(rep_vld === 1'b1 && rep_word === w, {tag, " reply"}, {15'h0, rep_vld, rep_word}, {16'h1, w});
        rep_pop = 1'b1;
        @(negedge clk);
        rep_pop = 1'b0;
    endtask

    task automatic expect_err(input string tag);
        check(s_act === 1'b0, {tag, " no action"}, 32'(s_act), 0);
        pop_expect(16'h9999, tag);
        check(rep_vld === 1'b0, {tag, " queue drained"}, 32'(rep_vld), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R3 actual hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(negedge clk);
        // R1: values while reset is held
        check(accept_req === 1 && init_done === 0 && rep_vld === 0 && act_vld === 0,
              "R1 during reset", {accept_req, init_done, rep_vld, act_vld}, 32'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(accept_req === 1 && init_done === 0 && rep_vld === 0 && act_vld === 0,
              "R1 reset state", {accept_req, init_done, rep_vld, act_vld}, 32'b1000);

        // R2: start-up gate with restarts
        cmd(4'h6);
        cmd(4'hB); cmd(4'h5);
        cmd(4'h2);
        send(1'b1, 8'h0B); cmd(4'h1);
        check(init_done === 0 && rep_vld === 0, "R2 still booting", {init_done, rep_vld}, 0);
        cmd(4'hB); cmd(4'h2);
        expect_act(4'hB, 8'h02, 16'h0, "R2 boot osc");
        check(init_done === 1 && osc_mode === 2, "R2 boot done", {init_done, osc_mode}, 32'b110);
        osc_exp = 2'd2;

        // R3: request drop then return
        check(s_acc === 0, "R3 drop after take", 32'(s_acc), 0);
        @(negedge clk);
        check(accept_req === 1, "R3 request back", 32'(accept_req), 1);

        // R4: register write
        cmd(4'h1); cmd(4'hA); cmd(4'h5); send_word(16'h1234);
        expect_act(4'h1, 8'hA5, 16'h1234, "R4 regwrite");

        // R5 / R7: volume range
        cmd(4'h6); cmd(4'h6);
        expect_act(4'h6, 8'h06, 16'h0, "R5 volume top");
        cmd(4'h6); cmd(4'h7); expect_err("R7 volume high");
        cmd(4'h6); cmd(4'h0); expect_err("R7 volume zero");

        // R7: unknown header then a fresh command
        cmd(4'hC); expect_err("R7 unknown header");
        cmd(4'h6); cmd(4'h3);
        expect_act(4'h6, 8'h03, 16'h0, "R7 next parsed as header");

        // R6: speed/pitch shift
        cmd(4'hA); cmd(4'h1); send_word(16'hF00D);
        expect_act(4'hA, 8'h01, 16'hF00D, "R6 shift");
        cmd(4'hA); cmd(4'h3); expect_err("R6 shift selector range");

        // R8: data nibble mid-command
        cmd(4'h1); cmd(4'h2); send(1'b1, 8'h07);
        check(s_data === 0, "R8 not forwarded", 32'(s_data), 0);
        expect_err("R8 abort");

        // R9: status reply
        buf_need = 16'h0123;
        cmd(4'h7); cmd(4'h2);
        expect_act(4'h7, 8'h02, 16'h0, "R9 status action");
        pop_expect(16'h0123, "R9");
        cmd(4'h7); cmd(4'h1); expect_err("R9 bad selector");

        // R10: data nibble outside a command
        send(1'b1, 8'hA9);
        check(s_data === 1 && s_dval === 8'h09, "R10 forward", {s_data, s_dval}, 32'h109);

        // R12: two replies fill the queue, order kept
        buf_need = 16'hBEEF;
        cmd(4'h7); cmd(4'h2);
        cmd(4'hE);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(accept_req === 0, "R12 full holds request", 32'(accept_req), 0);
        end
        pop_expect(16'hBEEF, "R12 first");
        check(accept_req === 1, "R12 request after pop", 32'(accept_req), 1);
        pop_expect(16'h9999, "R12 second");

        // R11: nibble playback
        cmd(4'h4); cmd(4'h1);
        check(playing === 1 && wide_mode === 0, "R11 nibble play", {playing, wide_mode}, 32'b10);
        send(1'b1, 8'h05);
        check(s_data === 1 && s_dval === 8'h05, "R11 data during play", {s_data, s_dval}, 32'h105);
        cmd(4'h6); cmd(4'h2);
        expect_act(4'h6, 8'h02, 16'h0, "R11 command during play");
        cmd(4'h5); cmd(4'h1);
        check(playing === 0, "R11 stop all", 32'(playing), 0);

        // R11: byte playback
        cmd(4'h4); cmd(4'h2);
        check(playing === 1 && wide_mode === 1, "R11 wide play", {playing, wide_mode}, 32'b11);
        send(1'b0, 8'h36);
        check(s_data === 1 && s_dval === 8'h36 && s_act === 0, "R11 wide forward",
              {s_act, s_data, s_dval}, 32'h136);
        @(negedge clk); play_end = 1'b1;
        @(negedge clk); play_end = 1'b0;
        check(playing === 0 && wide_mode === 0, "R11 play_end", {playing, wide_mode}, 0);
        cmd(4'h6); cmd(4'h2);
        expect_act(4'h6, 8'h02, 16'h0, "R11 back to commands");

        // R13: clock source change after start-up
        cmd(4'hB); cmd(4'h1);
        check(osc_mode === 1, "R13 osc change", 32'(osc_mode), 1);
        osc_exp = 2'd1;
        cmd(4'hB); cmd(4'h3); expect_err("R13 osc range");

        // Random commands: R4 R5 R6 R7 R9 R10 R13
        for (int n = 0; n < 300; n++) begin
            logic [3:0]  h, v;
            logic [7:0]  a;
            logic [15:0] w;
            h = 4'($urandom_range(0, 15));
            v = 4'($urandom_range(0, 15));
            a = 8'($urandom);
            w = 16'($urandom);
            if ($urandom_range(0, 7) == 0) begin
                send(1'b1, a);
                check(s_data === 1 && s_dval === {4'h0, a[3:0]}, "R10 random data",
                      {s_data, s_dval}, {1'b1, 4'h0, a[3:0]});
            end else if (!m_known(h)) begin
                cmd(h); expect_err("R7 random header");
            end else if (h == 4'h1) begin
                cmd(h); cmd(a[7:4]); cmd(a[3:0]); send_word(w);
                expect_act(h, a, w, "R4 random");
            end else begin
                if (h == 4'h4 && (v == 1 || v == 2 || v >= 4 && v <= 6)) v = 4'h3;
                buf_need = w;
                cmd(h); cmd(v);
                if (!m_sel_ok(h, v)) begin
                    expect_err("R7 random selector");
                end else if (h == 4'hA) begin
                    send_word(w);
                    expect_act(h, {4'h0, v}, w, "R6 random");
                end else begin
                    expect_act(h, {4'h0, v}, 16'h0, "R5 random");
                    if (h == 4'h7) pop_expect(w, "R9 random");
                    if (h == 4'hB) osc_exp = v[1:0];
                end
            end
        end
        check(osc_mode === osc_exp, "R13 random osc", 32'(osc_mode), 32'(osc_exp));
        check(rep_vld === 0 && playing === 0, "R12 idle at end", {rep_vld, playing}, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule